// File: doc/BRIEF.md
# Rail Residual-Voltage Check Sequencer

Before any power rail is switched on or off, this block confirms that the rail has discharged. A check is requested either by the automatic power sequence or by a register command, and names the rail and the direction (power-up or power-down). The block then samples that rail's residual comparator once per clock. It keeps a single cycle counter, cleared at the start of each check, and compares it with a limit of one power-up slot or eight power-down slots.

Each check ends with one of three outcomes. Proceed means the rail was already discharged. Residual event means the rail was charged at first but discharged in time. Timeout means the rail was still charged at the limit. The reaction depends on who asked. A command-initiated check that sees residual voltage only records a per-rail flag and raises an interrupt unless that interrupt is masked. A sequence-initiated check that times out marks the rail's shutdown flag, the timeout flag and a summary flag, and pulses a power-down request. A bypass setting suppresses that shutdown reaction and lets the rail be granted anyway.

Top module: `rv_check_seq`

## Requirements
- R1: After reset, reqReady is 1 and grantValid, doneValid, shutdownReq, intReq and all status flags are 0.
- R2: A request is accepted on the clock edge where reqValid and reqReady are both 1. The comparator is sampled on each following edge. If the first sample is 0, grantValid and doneValid are 1 for the cycle after that edge, doneOutcome is 0 (proceed), and grantRail equals the requested rail.
- R3: If the comparator reads 1 on the first H samples and 0 on sample H+1, with H+1 not above the limit, the grant and done pulses follow edge H+1 and doneOutcome is 1 (residual event).
- R4: The limit is PU_SLOT_CYCLES samples for a power-up check (reqDown=0) and PD_SLOT_MULT*PD_SLOT_CYCLES samples for a power-down check (reqDown=1). If every sample up to the limit reads 1, doneValid follows the limit-th sample with doneOutcome 2 (timeout). A 0 on the last allowed sample still grants.
- R5: A sequence check (reqCmd=0) that times out with bypass clear sets rvSdFlag for the rail, timeoutFlag and srcFlag. It also pulses shutdownReq for one cycle together with doneValid, and gives no grant.
- R6: A sequence check that times out with bypassRv set (sampled at acceptance) grants the rail. It sets no flag and makes no shutdown request.
- R7: A command check (reqCmd=1) that reads 1 on its first sample sets rvFlag for the rail. A command timeout sets timeoutFlag and gives no grant. No command check sets rvSdFlag or srcFlag or asserts shutdownReq.
- R8: intReq is 1 exactly when some rvFlag bit is 1 and maskRvInt is 0. maskRvInt does not change rvFlag.
- R9: While a check is running, reqReady is 0 and reqValid is ignored. The running check's rail, timing and outcome are unchanged.
- R10: A one-cycle statusClr clears all sticky flags. A flag set on the same edge stays set.
- R11: grantValid and doneValid are single-cycle pulses, with exactly one done pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Check request strobe |
| reqRail | input | IDX_W | Rail to check |
| reqCmd | input | 1 | 1 = register command, 0 = automatic sequence |
| reqDown | input | 1 | 1 = power-down limit, 0 = power-up limit |
| reqReady | output | 1 | Idle, request can be accepted |
| residual | input | NUM_RAILS | Per-rail comparator, 1 = residual voltage present |
| bypassRv | input | 1 | Suppress shutdown reaction for sequence checks |
| maskRvInt | input | 1 | Mask interrupt from rvFlag |
| statusClr | input | 1 | Clear all sticky flags |
| grantValid | output | 1 | Rail enable grant pulse |
| grantRail | output | IDX_W | Rail of the last grant |
| doneValid | output | 1 | Check finished pulse |
| doneOutcome | output | 2 | 0 proceed, 1 residual event, 2 timeout |
| shutdownReq | output | 1 | Power-down request pulse |
| rvFlag | output | NUM_RAILS | Sticky command residual flags |
| rvSdFlag | output | NUM_RAILS | Sticky sequence shutdown flags |
| timeoutFlag | output | 1 | Sticky timeout flag |
| srcFlag | output | 1 | Sticky summary flag for shutdown faults |
| intReq | output | 1 | Interrupt request, active high |

## Verification
The hardest cases are the discharge on the very last allowed sample and the discharge one sample too late. Both need the comparator to drop on an exact edge counted from acceptance, and the two limits differ by direction. The bench drives the comparator per sample from a chosen hold count H. It picks H at the boundaries L-1 and L as well as at random values, and it also tests a request made mid-check and a clear that coincides with a flag set.

// File: rtl/rv_check_pkg.sv
`timescale 1ns/1ps
package rv_check_pkg;
  typedef enum logic [1:0] {
    OUT_PROCEED = 2'd0,
    OUT_RVEVENT = 2'd1,
    OUT_TIMEOUT = 2'd2
  } outcome_e;

  typedef struct packed {
    logic     doGrant;
    logic     doDone;
    logic     setRv;
    logic     setTmo;
    logic     setSd;
    logic     pdReq;
    outcome_e outcome;
  } strobe_t;
endpackage

// File: rtl/rv_check_ctrl.sv
`timescale 1ns/1ps
module rv_check_ctrl
  import rv_check_pkg::*;
#(
  parameter int NUM_RAILS      = 4,
  parameter int PU_SLOT_CYCLES = 20,
  parameter int PD_SLOT_CYCLES = 6,
  parameter int PD_SLOT_MULT   = 8,
  localparam int IDX_W  = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1,
  localparam int PU_LIM = PU_SLOT_CYCLES,
  localparam int PD_LIM = PD_SLOT_MULT * PD_SLOT_CYCLES,
  localparam int MAX_LIM = (PD_LIM > PU_LIM) ? PD_LIM : PU_LIM,
  localparam int CNT_W  = $clog2(MAX_LIM) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [IDX_W-1:0]     reqRail,
  input  logic                 reqCmd,
  input  logic                 reqDown,
  input  logic                 bypassRv,
  input  logic [NUM_RAILS-1:0] residual,
  output logic                 reqReady,
  output logic [IDX_W-1:0]     railIdx,
  output strobe_t              strb
);
  typedef enum logic {ST_IDLE, ST_CHECK} state_e;

  state_e           state;
  logic [IDX_W-1:0] railQ;
  logic             cmdQ, downQ, bypassQ, sawRes;
  logic [CNT_W-1:0] cnt;
  logic             sample, lastSample;

  assign reqReady = (state == ST_IDLE);
  assign railIdx  = railQ;
  assign sample   = residual[railQ];
  assign lastSample = downQ ? (cnt == CNT_W'(PD_LIM - 1))
                            : (cnt == CNT_W'(PU_LIM - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      railQ   <= '0;
      cmdQ    <= 1'b0;
      downQ   <= 1'b0;
      bypassQ <= 1'b0;
      sawRes  <= 1'b0;
      cnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_CHECK;
            railQ   <= reqRail;
            cmdQ    <= reqCmd;
            downQ   <= reqDown;
            bypassQ <= bypassRv;
            sawRes  <= 1'b0;
            cnt     <= '0;
          end
        end
        default: begin
          if (strb.doDone) begin
            state <= ST_IDLE;
          end else begin
            cnt    <= cnt + 1'b1;
            sawRes <= 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb = '0;
    strb.outcome = OUT_PROCEED;
    if (state == ST_CHECK) begin
      if (!sample) begin
        strb.doGrant = 1'b1;
        strb.doDone  = 1'b1;
        strb.outcome = sawRes ? OUT_RVEVENT : OUT_PROCEED;
      end else begin
        strb.setRv = cmdQ;
        if (lastSample) begin
          strb.doDone  = 1'b1;
          strb.outcome = OUT_TIMEOUT;
          if (cmdQ) begin
            strb.setTmo = 1'b1;
          end else if (bypassQ) begin
            strb.doGrant = 1'b1;
          end else begin
            strb.setTmo = 1'b1;
            strb.setSd  = 1'b1;
            strb.pdReq  = 1'b1;
          end
        end
      end
    end
  end

  assert_cnt_bound_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !downQ) |-> (cnt < CNT_W'(PU_LIM)));
  assert_cnt_bound_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && downQ) |-> (cnt < CNT_W'(PD_LIM)));
  assert_rail_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && reqValid) |=> $stable(railQ));
  assert_cmd_no_sd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && cmdQ) |-> !strb.pdReq);
endmodule

// File: rtl/rv_check_dp.sv
`timescale 1ns/1ps
module rv_check_dp
  import rv_check_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  localparam int IDX_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [IDX_W-1:0]     railIdx,
  input  logic                 statusClr,
  input  logic                 maskRvInt,
  output logic                 grantValid,
  output logic [IDX_W-1:0]     grantRail,
  output logic                 doneValid,
  output logic [1:0]           doneOutcome,
  output logic                 shutdownReq,
  output logic [NUM_RAILS-1:0] rvFlag,
  output logic [NUM_RAILS-1:0] rvSdFlag,
  output logic                 timeoutFlag,
  output logic                 srcFlag,
  output logic                 intReq
);
  outcome_e outcomeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid  <= 1'b0;
      grantRail   <= '0;
      doneValid   <= 1'b0;
      outcomeQ    <= OUT_PROCEED;
      shutdownReq <= 1'b0;
      timeoutFlag <= 1'b0;
      srcFlag     <= 1'b0;
    end else begin
      grantValid  <= strb.doGrant;
      doneValid   <= strb.doDone;
      shutdownReq <= strb.pdReq;
      if (strb.doGrant) grantRail <= railIdx;
      if (strb.doDone)  outcomeQ  <= strb.outcome;
      timeoutFlag <= strb.setTmo | (timeoutFlag & ~statusClr);
      srcFlag     <= strb.setSd  | (srcFlag & ~statusClr);
    end
  end

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    logic hit;
    assign hit = (railIdx == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rvFlag[g]   <= 1'b0;
        rvSdFlag[g] <= 1'b0;
      end else begin
        rvFlag[g]   <= (hit & strb.setRv) | (rvFlag[g]   & ~statusClr);
        rvSdFlag[g] <= (hit & strb.setSd) | (rvSdFlag[g] & ~statusClr);
      end
    end
  end

  assign doneOutcome = outcomeQ;
  assign intReq      = (|rvFlag) & ~maskRvInt;

  assert_grant_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  assert_grant_has_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> doneValid);
  assert_shutdown_timeout_R5: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> (doneValid && doneOutcome == 2'd2 && timeoutFlag && srcFlag && !grantValid));
  assert_sd_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|rvSdFlag) |-> shutdownReq);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !strb.doDone) |=> (!timeoutFlag && !srcFlag));
endmodule

// File: rtl/rv_check_seq.sv
`timescale 1ns/1ps
module rv_check_seq
  import rv_check_pkg::*;
#(
  parameter int NUM_RAILS      = 4,
  parameter int PU_SLOT_CYCLES = 20,
  parameter int PD_SLOT_CYCLES = 6,
  parameter int PD_SLOT_MULT   = 8,
  localparam int IDX_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [IDX_W-1:0]     reqRail,
  input  logic                 reqCmd,
  input  logic                 reqDown,
  output logic                 reqReady,
  input  logic [NUM_RAILS-1:0] residual,
  input  logic                 bypassRv,
  input  logic                 maskRvInt,
  input  logic                 statusClr,
  output logic                 grantValid,
  output logic [IDX_W-1:0]     grantRail,
  output logic                 doneValid,
  output logic [1:0]           doneOutcome,
  output logic                 shutdownReq,
  output logic [NUM_RAILS-1:0] rvFlag,
  output logic [NUM_RAILS-1:0] rvSdFlag,
  output logic                 timeoutFlag,
  output logic                 srcFlag,
  output logic                 intReq
);
  strobe_t          strb;
  logic [IDX_W-1:0] railIdx;

  rv_check_ctrl #(
    .NUM_RAILS(NUM_RAILS), .PU_SLOT_CYCLES(PU_SLOT_CYCLES),
    .PD_SLOT_CYCLES(PD_SLOT_CYCLES), .PD_SLOT_MULT(PD_SLOT_MULT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRail(reqRail),
    .reqCmd(reqCmd), .reqDown(reqDown), .bypassRv(bypassRv),
    .residual(residual), .reqReady(reqReady), .railIdx(railIdx), .strb(strb)
  );

  rv_check_dp #(.NUM_RAILS(NUM_RAILS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .railIdx(railIdx),
    .statusClr(statusClr), .maskRvInt(maskRvInt),
    .grantValid(grantValid), .grantRail(grantRail), .doneValid(doneValid),
    .doneOutcome(doneOutcome), .shutdownReq(shutdownReq), .rvFlag(rvFlag),
    .rvSdFlag(rvSdFlag), .timeoutFlag(timeoutFlag), .srcFlag(srcFlag),
    .intReq(intReq)
  );
endmodule

// File: tb/rv_check_seq_bench.sv
`timescale 1ns/1ps
module rv_check_seq_bench;
  localparam int NR = 4;
  localparam int PU = 20;
  localparam int PD = 6;
  localparam int PM = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [IW-1:0] reqRail = '0;
  logic          reqCmd = 1'b0, reqDown = 1'b0;
  logic          reqReady;
  logic [NR-1:0] residual = '0;
  logic          bypassRv = 1'b0, maskRvInt = 1'b0, statusClr = 1'b0;
  logic          grantValid, doneValid, shutdownReq, timeoutFlag, srcFlag, intReq;
  logic [IW-1:0] grantRail;
  logic [1:0]    doneOutcome;
  logic [NR-1:0] rvFlag, rvSdFlag;

  int total = 0;
  int bad = 0;
  logic [NR-1:0] expRv = '0, expSd = '0;
  logic          expTmo = 1'b0, expSrc = 1'b0;

  always #2.5 clk = ~clk;

  rv_check_seq #(.NUM_RAILS(NR), .PU_SLOT_CYCLES(PU), .PD_SLOT_CYCLES(PD),
                 .PD_SLOT_MULT(PM)) u_rv_check_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRail(reqRail),
    .reqCmd(reqCmd), .reqDown(reqDown), .reqReady(reqReady),
    .residual(residual), .bypassRv(bypassRv), .maskRvInt(maskRvInt),
    .statusClr(statusClr), .grantValid(grantValid), .grantRail(grantRail),
    .doneValid(doneValid), .doneOutcome(doneOutcome), .shutdownReq(shutdownReq),
    .rvFlag(rvFlag), .rvSdFlag(rvSdFlag), .timeoutFlag(timeoutFlag),
    .srcFlag(srcFlag), .intReq(intReq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int limitOf(input bit down);
    return down ? PD * PM : PU;
  endfunction

  function automatic int expOutcome(input int h, input int lim);
    if (h >= lim) return 2;
    return (h == 0) ? 0 : 1;
  endfunction

  task automatic checkFlags(input string req);
    chk(req, "rvFlag", int'(rvFlag), int'(expRv));
    chk(req, "rvSdFlag", int'(rvSdFlag), int'(expSd));
    chk(req, "timeoutFlag", int'(timeoutFlag), int'(expTmo));
    chk(req, "srcFlag", int'(srcFlag), int'(expSrc));
    chk("R8", "intReq", int'(intReq), int'((|expRv) & ~maskRvInt));
  endtask

  // One check: comparator of `rail` reads 1 for the first h samples.
  task automatic runCheck(input int rail, input bit cmd, input bit down,
                          input bit byp, input bit mask, input int h,
                          input bit poke, input bit clrFirst);
    int  lim = limitOf(down);
    bit  tmo = (h >= lim);
    int  nExp = tmo ? lim : h + 1;
    bit  gExp = !tmo || (!cmd && byp);
    int  nGot = 0;
    string rq = tmo ? "R4" : ((h == 0) ? "R2" : "R3");
    @(negedge clk);
    residual = 4'($urandom);
    residual[rail] = (h >= 1);
    reqValid = 1'b1; reqRail = IW'(rail); reqCmd = cmd; reqDown = down;
    bypassRv = byp; maskRvInt = mask;
    @(negedge clk);
    reqValid = 1'b0;
    bypassRv = ~byp;
    if (clrFirst) statusClr = 1'b1;
    for (int n = 1; n <= lim + 2; n++) begin
      @(negedge clk);
      statusClr = 1'b0;
      if (n == 1 && clrFirst) begin
        expRv = '0; expSd = '0; expTmo = 1'b0; expSrc = 1'b0;
      end
      if (n == 2 && poke) reqValid = 1'b0;
      if (doneValid) begin nGot = n; break; end
      if (n == 1 && poke) begin
        chk("R9", "reqReady busy", int'(reqReady), 0);
        reqValid = 1'b1; reqRail = IW'((rail + 1) % NR); reqCmd = ~cmd; reqDown = ~down;
      end
      residual[rail] = (n + 1 <= h);
    end
    reqValid = 1'b0;
    if (cmd && h > 0) expRv[rail] = 1'b1;
    if (tmo) begin
      if (cmd) expTmo = 1'b1;
      else if (!byp) begin expSd[rail] = 1'b1; expTmo = 1'b1; expSrc = 1'b1; end
    end
    chk(rq, "done cycle", nGot, nExp);
    chk(rq, "outcome", int'(doneOutcome), expOutcome(h, lim));
    chk(tmo ? (cmd ? "R7" : (byp ? "R6" : "R5")) : rq, "grant", int'(grantValid), int'(gExp));
    if (gExp) chk(poke ? "R9" : "R2", "grantRail", int'(grantRail), rail);
    chk("R5", "shutdownReq", int'(shutdownReq), int'(tmo && !cmd && !byp));
    checkFlags(clrFirst ? "R10" : (cmd ? "R7" : "R5"));
    @(negedge clk);
    chk("R11", "done pulse width", int'(doneValid), 0);
    chk("R11", "grant pulse width", int'(grantValid), 0);
    chk("R1", "ready after", int'(reqReady), 1);
  endtask

  task automatic clearAll();
    @(negedge clk);
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    expRv = '0; expSd = '0; expTmo = 1'b0; expSrc = 1'b0;
    checkFlags("R10");
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reqReady", int'(reqReady), 1);
    chk("R1", "grantValid", int'(grantValid), 0);
    chk("R1", "doneValid", int'(doneValid), 0);
    chk("R1", "shutdownReq", int'(shutdownReq), 0);
    checkFlags("R1");

    // directed corners
    runCheck(1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0);       // R2 proceed
    runCheck(2, 1'b0, 1'b0, 1'b0, 1'b0, 5, 1'b0, 1'b0);       // R3
    runCheck(3, 1'b0, 1'b0, 1'b0, 1'b0, PU - 1, 1'b0, 1'b0);  // R4 last sample grants
    runCheck(0, 1'b0, 1'b0, 1'b0, 1'b0, PU, 1'b0, 1'b0);      // R5 timeout
    clearAll();
    runCheck(1, 1'b0, 1'b1, 1'b0, 1'b0, PD * PM - 1, 1'b0, 1'b0); // R4 down boundary
    runCheck(2, 1'b0, 1'b1, 1'b0, 1'b0, PD * PM, 1'b0, 1'b0);     // R4 down timeout
    runCheck(3, 1'b0, 1'b0, 1'b1, 1'b0, PU + 3, 1'b0, 1'b0);  // R6 bypass
    clearAll();
    runCheck(2, 1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b0);       // R7 rv event
    @(negedge clk);
    maskRvInt = 1'b1;
    #1 chk("R8", "intReq masked", int'(intReq), 0);
    chk("R8", "rvFlag kept under mask", int'(rvFlag), int'(expRv));
    runCheck(0, 1'b1, 1'b1, 1'b0, 1'b1, PD * PM, 1'b0, 1'b0); // R7 timeout
    runCheck(1, 1'b0, 1'b0, 1'b0, 1'b0, 6, 1'b1, 1'b0);       // R9 poke
    runCheck(3, 1'b1, 1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b1);       // R10 set wins

    // constrained random
    for (int i = 0; i < 60; i++) begin
      int  rail = int'($urandom_range(NR - 1, 0));
      bit  cmd  = 1'($urandom);
      bit  down = 1'($urandom);
      bit  byp  = 1'($urandom);
      bit  msk  = 1'($urandom);
      int  lim  = limitOf(down);
      int  sel  = int'($urandom_range(5, 0));
      int  h;
      case (sel)
        0: h = 0;
        1: h = lim - 1;
        2: h = lim;
        3: h = lim + int'($urandom_range(4, 1));
        default: h = int'($urandom_range(lim - 1, 1));
      endcase
      runCheck(rail, cmd, down, byp, msk, h, (h >= 2) && ($urandom_range(3, 0) == 0), 1'b0);
      if ($urandom_range(4, 0) == 0) clearAll();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule